// File: doc/BRIEF.md
# Watchdog and Periodic Time-Base Timer

This block watches for a host that stops responding, and it also provides a regular time base. A slow tick with a nominal period of 250 µs drives a tick counter. The tick comes from one of two sources:

- the master (system) clock divided by a fixed ratio, or
- a frame-sync input divided by two.

A 16-bit timeout register sets the length of one period. The register holds the period as decimal seconds, milliseconds and quarter-milliseconds. The block converts these fields into a number of ticks.

If the host does not clear the counter before that many ticks pass, the block does three things:

- it raises a one-cycle timer interrupt;
- it drives the watchdog output high for one tick period;
- it restarts counting from zero.

While the host stays silent, both the interrupt and the watchdog pulse repeat once per period. A disable input stops the counter and silences both outputs.

The host loads the timeout register with a write strobe and data word. It clears the counter with a single-cycle strobe. The interrupt output feeds an interrupt collector outside this block.

Top module: `wdt_timebase`

## Requirements
- R1: After reset, the timeout register holds 0x0800, which is 512 ms or 2048 ticks. The interrupt and watchdog outputs are low.
- R2: With tick_sel_i = 0, one tick occurs every MCLK_DIV system clocks (default 8192).
- R3: With tick_sel_i = 1, one tick occurs on every second rising edge of fs_i, after a two-flop synchroniser.
- R4: The timeout register fields are decoded as follows, and the terminal count is T = sec × 4000 + ms × 4 + qms ticks.
  - sec is bits 15..12.
  - ms is bits 11..2.
  - qms is bits 1..0.
- R5: A sec field above 5 is treated as 5. An ms field above 999 is treated as 999.
- R6: A terminal count below 4 ticks is raised to 4.
- R7: The period expires on the T-th tick after a clear or after the previous expiry, and counting then restarts from zero. On expiry, irq_o is high for exactly one system clock.
- R8: wdo_o goes high in the same cycle as irq_o. It stays high until the next tick, so it lasts exactly one tick period.
- R9: A pulse on wd_clr_i returns the count to zero on the next clock edge. If the pulse lands on the same edge as a tick, the clear wins and no expiry occurs.
- R10: While dis_i is high, the count is held at zero and neither irq_o nor wdo_o is raised. A wdo_o pulse already in progress is dropped.
- R11: If the register is rewritten to a terminal count at or below the current count, the period expires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (master) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame-sync clock, asynchronous to clk_i |
| tick_sel_i | input | 1 | Tick source select: 1 = frame-sync divided by two, 0 = clock divider |
| dis_i | input | 1 | Disables the timer and both outputs |
| tmr_we_i | input | 1 | Write strobe for the timeout register |
| tmr_wdata_i | input | 16 | Timeout value: sec in [15:12], ms in [11:2], qms in [1:0] |
| wd_clr_i | input | 1 | Counter clear strobe from the host |
| irq_o | output | 1 | One-cycle timer interrupt at each expiry |
| wdo_o | output | 1 | Watchdog pulse, one tick period long |

## Verification
The bench targets the decimal conversion at its edges:

- A design that saturated the wrong field, or wrapped the fields instead of saturating them, would expire far too early.
- The four-tick floor is probed from both sides. A missing floor gives sub-millisecond periods.

The bench measures the latency from a clear to expiry against a window one tick wide. An off-by-one terminal compare lands a tick late. A missing auto-restart loses the second interrupt.

Further directed cases cover the following:

- a clear stream that must keep the interrupt silent;
- disable arriving in the middle of a wdo_o pulse, which must end the pulse;
- the register being lowered below the running count, which must give an immediate expiry instead of a wrap through 2^15 ticks;
- the frame-sync source, whose divide-by-two would show up as a doubled period if it were wrong.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned LIMIT_W       = 15;
  localparam int unsigned SEC_MAX       = 5;
  localparam int unsigned MS_MAX        = 999;
  localparam int unsigned TICKS_PER_SEC = 4000;
  localparam int unsigned TICKS_PER_MS  = 4;
  localparam int unsigned MIN_TICKS     = 4;
  localparam logic [15:0] REG_RST       = 16'h0800;

  typedef struct packed {
    logic [3:0] sec;
    logic [9:0] ms;
    logic [1:0] qms;
  } tmr_reg_t;

  typedef logic [LIMIT_W-1:0] ticks_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned MCLK_DIV = 8192,
  parameter int unsigned FS_DIV   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_i,
  input  logic sel_i,
  output logic tick_o
);
  localparam int unsigned MC_CW = (MCLK_DIV > 1) ? $clog2(MCLK_DIV) : 1;
  localparam int unsigned FS_CW = (FS_DIV > 1) ? $clog2(FS_DIV) : 1;

  logic             mc_tick, fs_tick, fs_rise;
  logic [2:0]       fs_q;
  logic [FS_CW-1:0] fs_cnt;

  // Synchronise the frame-sync input into the system clock domain, then detect rising edges.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= '0;
    else         fs_q <= {fs_q[1:0], fs_i};
  end
  assign fs_rise = fs_q[1] & ~fs_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fs_cnt <= '0;
    else if (fs_rise) fs_cnt <= (fs_cnt == FS_CW'(FS_DIV - 1)) ? '0 : fs_cnt + FS_CW'(1);
  end
  assign fs_tick = fs_rise && (fs_cnt == FS_CW'(FS_DIV - 1));

  generate
    if (MCLK_DIV > 1) begin : g_mdiv
      logic [MC_CW-1:0] mc_cnt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mc_cnt <= '0;
        else         mc_cnt <= mc_tick ? '0 : mc_cnt + MC_CW'(1);
      end
      assign mc_tick = (mc_cnt == MC_CW'(MCLK_DIV - 1));

      // R2
      mc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mc_tick |=> !mc_tick);
    end else begin : g_mpass
      assign mc_tick = 1'b1;
    end
  endgenerate

  assign tick_o = sel_i ? fs_tick : mc_tick;
endmodule

// File: rtl/wdt_limit.sv
module wdt_limit
  import wdt_pkg::*;
(
  input  tmr_reg_t reg_i,
  output ticks_t   limit_o
);
  ticks_t sec_v, ms_v, qms_v, raw;

  always_comb begin
    sec_v = (reg_i.sec > 4'(SEC_MAX)) ? ticks_t'(SEC_MAX) : ticks_t'(reg_i.sec);
    ms_v  = (reg_i.ms > 10'(MS_MAX))  ? ticks_t'(MS_MAX)  : ticks_t'(reg_i.ms);
    qms_v = ticks_t'(reg_i.qms);
    raw   = sec_v * ticks_t'(TICKS_PER_SEC) + ms_v * ticks_t'(TICKS_PER_MS) + qms_v;
    limit_o = (raw < ticks_t'(MIN_TICKS)) ? ticks_t'(MIN_TICKS) : raw;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   dis_i,
  input  logic   wd_clr_i,
  input  ticks_t limit_i,
  output logic   irq_o,
  output logic   wdo_o
);
  ticks_t cnt;
  logic   hit;

  // >= rather than == so a lowered limit expires on the next tick instead of wrapping.
  assign hit = (cnt >= limit_i - ticks_t'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      irq_o <= 1'b0;
      wdo_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (dis_i) begin
        cnt   <= '0;
        wdo_o <= 1'b0;
      end else begin
        if (tick_i && wdo_o) wdo_o <= 1'b0;
        if (wd_clr_i) begin
          cnt <= '0;
        end else if (tick_i) begin
          if (hit) begin
            cnt   <= '0;
            irq_o <= 1'b1;
            wdo_o <= 1'b1;
          end else begin
            cnt <= cnt + ticks_t'(1);
          end
        end
      end
    end
  end

  // R7
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  wdo_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdo_o) |-> irq_o);
  // R9
  clr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_clr_i |=> !irq_o);
  // R10
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> (!irq_o && !wdo_o));
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase
  import wdt_pkg::*;
#(
  parameter int unsigned MCLK_DIV = 8192,
  parameter int unsigned FS_DIV   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fs_i,
  input  logic        tick_sel_i,
  input  logic        dis_i,
  input  logic        tmr_we_i,
  input  logic [15:0] tmr_wdata_i,
  input  logic        wd_clr_i,
  output logic        irq_o,
  output logic        wdo_o
);
  tmr_reg_t tmr_q;
  ticks_t   limit;
  logic     tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tmr_q <= tmr_reg_t'(REG_RST);
    else if (tmr_we_i) tmr_q <= tmr_reg_t'(tmr_wdata_i);
  end

  wdt_tick_gen #(.MCLK_DIV(MCLK_DIV), .FS_DIV(FS_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fs_i   (fs_i),
    .sel_i  (tick_sel_i),
    .tick_o (tick)
  );

  wdt_limit u_limit (
    .reg_i   (tmr_q),
    .limit_o (limit)
  );

  wdt_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .dis_i    (dis_i),
    .wd_clr_i (wd_clr_i),
    .limit_i  (limit),
    .irq_o    (irq_o),
    .wdo_o    (wdo_o)
  );
endmodule

// File: tb/wdt_timebase_test.sv
module wdt_timebase_test;
  localparam int D  = 2;  // system clocks per tick, clock-divider source
  localparam int DF = 8;  // system clocks per tick, frame-sync source (fs period 4 clocks, /2)

  logic        clk = 0, rst_n = 0, fs = 0, sel = 0, dis = 0, we = 0, clr = 0;
  logic [15:0] wd = '0;
  wire         irq, wdo;
  int          checks = 0, errors = 0, irq_cnt = 0, wdo_cnt = 0;
  bit          done = 0;

  wdt_timebase #(.MCLK_DIV(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fs_i(fs), .tick_sel_i(sel), .dis_i(dis),
    .tmr_we_i(we), .tmr_wdata_i(wd), .wd_clr_i(clr), .irq_o(irq), .wdo_o(wdo)
  );

  always #4 clk = ~clk;
  initial begin #1; forever #16 fs = ~fs; end
  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (wdo) wdo_cnt++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] v);
    @(negedge clk); wd = v; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic kick();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic wait_irq(int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq) begin n = i; return; end
    end
  endtask

  // clear, then expect expiry within one tick of T ticks
  task automatic lat(int t, int d, string req);
    int n;
    kick();
    wait_irq(t * d + 4, n);
    chk(n >= d * (t - 1) + 1 && n <= d * t, req, n, d * t);
  endtask

  task automatic per(int t, int d, string req);
    int n;
    wait_irq(t * d + 4, n);
    chk(n == t * d, req, n, t * d);
  endtask

  task automatic t_reset();
    chk(irq == 0 && wdo == 0, "R1 outputs after reset", {irq, wdo}, 0);
    lat(2048, D, "R1 default latency");
    per(2048, D, "R2 R7 default period");
  endtask

  task automatic t_fields();
    wr(16'h0009); lat(9, D, "R4 ms=2 qms=1");  per(9, D, "R4 R7 period 9");
    wr(16'h0006); lat(6, D, "R4 ms=1 qms=2");  per(6, D, "R4 period 6");
    wr(16'h1000); lat(4000, D, "R4 sec=1");
  endtask

  task automatic t_sat();
    wr(16'h0FFC); lat(3996, D, "R5 ms saturates at 999");
    wr(16'hF000); lat(20000, D, "R5 sec saturates at 5");
  endtask

  task automatic t_min();
    wr(16'h0000); lat(4, D, "R6 zero raised to 4"); per(4, D, "R6 period 4");
    wr(16'h0003); lat(4, D, "R6 three raised to 4"); per(4, D, "R6 period at 3");
    wr(16'h0005); lat(5, D, "R6 five kept");        per(5, D, "R6 period 5");
  endtask

  task automatic t_wdo(int d, string req);
    int w = 1, n;
    wait_irq(10 * d + 4, n);
    chk(wdo == 1, {req, " wdo with irq"}, wdo, 1);
    @(posedge clk); @(negedge clk);
    chk(irq == 0, {req, " irq one cycle"}, irq, 0);
    while (wdo && w < 100) begin
      w++;
      @(posedge clk); @(negedge clk);
    end
    chk(w == d, {req, " wdo width"}, w, d);
  endtask

  task automatic t_clear();
    int base;
    wr(16'h000A);
    kick();
    base = irq_cnt;
    for (int k = 0; k < 10; k++) begin
      kick();
      repeat (13) @(negedge clk);
    end
    chk(irq_cnt == base, "R9 clears keep irq silent", irq_cnt - base, 0);
    lat(10, D, "R9 expiry after last clear");
  endtask

  task automatic t_disable();
    int bi, bw, n;
    wr(16'h0000);
    kick();
    wait_irq(20, n);
    dis = 1;
    @(negedge clk);
    chk(wdo == 0, "R10 wdo dropped by disable", wdo, 0);
    bi = irq_cnt; bw = wdo_cnt;
    repeat (100) @(negedge clk);
    chk(irq_cnt == bi, "R10 no irq while disabled", irq_cnt - bi, 0);
    chk(wdo_cnt == bw, "R10 no wdo while disabled", wdo_cnt - bw, 0);
    dis = 0;
    lat(4, D, "R10 resumes after enable");
  endtask

  task automatic t_fs();
    sel = 1;
    wr(16'h0005);
    lat(5, DF, "R3 frame-sync latency");
    per(5, DF, "R3 frame-sync period");
    t_wdo(DF, "R3 R8 frame-sync");
    sel = 0;
  endtask

  task automatic t_lower();
    int n;
    wr(16'h0190);
    kick();
    repeat (100) @(negedge clk);
    wr(16'h0010);
    wait_irq(4, n);
    chk(n >= 1 && n <= D, "R11 lowered limit expires next tick", n, D);
    per(16, D, "R11 new period");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_sat();
    t_min();
    wr(16'h0006); kick();
    t_wdo(D, "R8 clock source");
    t_clear();
    t_disable();
    t_fs();
    t_lower();
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    summary();
  end
endmodule